// File: doc/BRIEF.md
# Full-Bridge PWM Direction Steering

This block drives the four switch legs of an H-bridge from a single pulse-width modulator. In each direction one leg is held on while the leg diagonally across from it carries the modulated waveform. Forward uses held leg A with modulated leg D. Reverse uses held leg C with modulated leg B. A prescaled counter sets the period, and a duty comparator shapes the modulated leg.

A direction change is never applied in the middle of a period. When the requested direction differs from the one in effect, the swap waits for the last four counter values of the current period. During that window both modulated legs are forced low and the held-on leg moves across to the new side. The new direction then runs normally from the start of the next period. No dead-band is inserted at any point.

The controller has five states. `ST_IDLE` is the disabled state. `ST_FWD` and `ST_REV` are the two running directions. `ST_F2R` and `ST_R2F` are the two swap windows. The transitions are:

- **start**: `ST_IDLE`→`ST_FWD` when enabled.
- **arm-reverse**: `ST_FWD`→`ST_F2R` when the window opens with reverse requested.
- **arm-forward**: `ST_REV`→`ST_R2F` when the window opens with forward requested.
- **commit-reverse**: `ST_F2R`→`ST_REV` at the period boundary.
- **commit-forward**: `ST_R2F`→`ST_FWD` at the period boundary.
- **stop**: any state→`ST_IDLE` when enable is low.

Top module: `fb_bridge_pwm`

## Requirements
- R1: While reset is asserted or `en` is low, all four outputs are low and the counter is held at zero. One cycle after `en` rises, the block runs in forward direction with the counter at 0.
- R2: Forward direction: `out_a` is high, `out_b` and `out_c` are low, and `out_d` is high exactly while the counter is below the latched duty.
- R3: Reverse direction: `out_c` is high, `out_a` and `out_d` are low, and `out_b` is high exactly while the counter is below the latched duty.
- R4: No more than two outputs are high at once. `out_a` and `out_c` are never both high. `out_b` and `out_d` are never both high.
- R5: The counter advances once per prescaled tick. `psc_sel` selects the tick length: 00 gives 1 clock, 01 gives 4 clocks, and 10 or 11 gives 16 clocks.
- R6: The counter runs from 0 up to the period value and then returns to 0. A period value below 4 is treated as 4.
- R7: The duty value is captured when a period starts, and changes made during a period apply from the next one. A duty of 0 keeps the modulated leg low. A duty above the period keeps it high for the whole period.
- R8: `dir_rev` (1 = reverse, 0 = forward) takes effect at the next period start. If the request differs from the direction in effect when the counter reaches period−3, then for the four counter values period−3..period both modulated legs are low and only the new held leg is high.
- R9: A direction request that is withdrawn before the window opens causes no swap, and modulation continues unchanged.
- R10: A request raised after the window has opened is handled in the next period's window.
- R11: Dropping `en` makes all outputs low one cycle later. A later re-enable starts in forward direction, whatever the level of `dir_rev`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Run enable |
| dir_rev | input | 1 | Requested direction, 1 = reverse |
| psc_sel | input | 2 | Tick length select |
| period | input | CNT_W | Last counter value of a period |
| duty | input | CNT_W | Modulated-leg on-count |
| out_a | output | 1 | Forward held leg |
| out_b | output | 1 | Reverse modulated leg |
| out_c | output | 1 | Reverse held leg |
| out_d | output | 1 | Forward modulated leg |

## Verification
The outputs are decoded directly from the state register and the counter, so every output follows within the clock edge that updates them.

- A change to `en` is seen at the outputs one cycle later.
- Duty and direction changes are seen only at the first counter value of a period boundary or of a window, never at the cycle the input moves.
- The bench numbers the cycles from the first enabled cycle. For each cycle it derives the tick index, the period index and the counter value from the requirements, and then compares all four outputs at the falling edge.
- Inputs are changed only at a falling edge. The cycle in which a request is raised relative to the window entry therefore decides, by construction of the test, which period's window performs the swap.

// File: rtl/fb_pkg.sv
package fb_pkg;

    // width of the tick-length counter (largest divisor is 16)
    localparam int PSC_W      = 5;
    // number of counter values in the pre-boundary swap window
    localparam int WIN_TICKS  = 4;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_FWD  = 3'd1,
        ST_REV  = 3'd2,
        ST_F2R  = 3'd3,
        ST_R2F  = 3'd4
    } steer_state_t;

    // clocks per tick for a select code: 00 -> 1, 01 -> 4, 1x -> 16
    function automatic logic [PSC_W-1:0] psc_divisor(input logic [1:0] sel);
        logic [PSC_W-1:0] d;
        case (sel)
            2'b00:   d = PSC_W'(1);
            2'b01:   d = PSC_W'(4);
            default: d = PSC_W'(16);
        endcase
        return d;
    endfunction

endpackage

// File: rtl/fb_prescaler.sv
module fb_prescaler
    import fb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [1:0] sel,
    output logic       tick
);

    logic [PSC_W-1:0] pcnt_q;
    logic [PSC_W-1:0] last_val;

    always_comb begin
        last_val = psc_divisor(sel) - PSC_W'(1);
    end

    // >= keeps ticking if the select shrinks below the running count
    assign tick = run && (pcnt_q >= last_val);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pcnt_q <= '0;
        end else if (!run || tick) begin
            pcnt_q <= '0;
        end else begin
            pcnt_q <= pcnt_q + PSC_W'(1);
        end
    end

endmodule

// File: rtl/fb_period_timer.sv
module fb_period_timer
    import fb_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic [CNT_W-1:0] period,
    input  logic [CNT_W-1:0] duty,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] duty_q,
    output logic [CNT_W-1:0] per_eff,
    output logic             enter_win,
    output logic             boundary
);

    localparam logic [CNT_W-1:0] MIN_PER = CNT_W'(WIN_TICKS);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] duty_lat_q;

    always_comb begin
        per_eff = (period < MIN_PER) ? MIN_PER : period;
    end

    // last tick of a period
    assign boundary  = tick && (cnt_q >= per_eff);
    // last tick before the counter enters per_eff-3
    assign enter_win = tick && (cnt_q == per_eff - MIN_PER);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || boundary) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            duty_lat_q <= '0;
        end else if (!run || boundary) begin
            duty_lat_q <= duty;
        end
    end

    assign cnt    = cnt_q;
    assign duty_q = duty_lat_q;

endmodule

// File: rtl/fb_steer_fsm.sv
module fb_steer_fsm
    import fb_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             dir_rev,
    input  logic             enter_win,
    input  logic             boundary,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] duty_q,
    output logic             run,
    output logic             drv_a,
    output logic             drv_b,
    output logic             drv_c,
    output logic             drv_d
);

    steer_state_t state_q;
    steer_state_t state_d;
    logic         pwm_on;

    assign run    = en && (state_q != ST_IDLE);
    assign pwm_on = (cnt < duty_q);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        if (!en) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: state_d = ST_FWD;
                ST_FWD:  if (enter_win && dir_rev)  state_d = ST_F2R;
                ST_REV:  if (enter_win && !dir_rev) state_d = ST_R2F;
                ST_F2R:  if (boundary)              state_d = ST_REV;
                ST_R2F:  if (boundary)              state_d = ST_FWD;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // output decode
    always_comb begin
        drv_a = 1'b0;
        drv_b = 1'b0;
        drv_c = 1'b0;
        drv_d = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_FWD: begin
                drv_a = 1'b1;
                drv_d = pwm_on;
            end
            ST_REV: begin
                drv_c = 1'b1;
                drv_b = pwm_on;
            end
            ST_F2R:  drv_c = 1'b1;
            ST_R2F:  drv_a = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/fb_bridge_pwm.sv
module fb_bridge_pwm
    import fb_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             dir_rev,
    input  logic [1:0]       psc_sel,
    input  logic [CNT_W-1:0] period,
    input  logic [CNT_W-1:0] duty,
    output logic             out_a,
    output logic             out_b,
    output logic             out_c,
    output logic             out_d
);

    logic             run_w;
    logic             tick_w;
    logic             enter_win_w;
    logic             boundary_w;
    logic [CNT_W-1:0] cnt_w;
    logic [CNT_W-1:0] duty_q_w;
    logic [CNT_W-1:0] per_eff_w;

    fb_prescaler u_psc (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run_w),
        .sel   (psc_sel),
        .tick  (tick_w)
    );

    fb_period_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run_w),
        .tick      (tick_w),
        .period    (period),
        .duty      (duty),
        .cnt       (cnt_w),
        .duty_q    (duty_q_w),
        .per_eff   (per_eff_w),
        .enter_win (enter_win_w),
        .boundary  (boundary_w)
    );

    fb_steer_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .dir_rev   (dir_rev),
        .enter_win (enter_win_w),
        .boundary  (boundary_w),
        .cnt       (cnt_w),
        .duty_q    (duty_q_w),
        .run       (run_w),
        .drv_a     (out_a),
        .drv_b     (out_b),
        .drv_c     (out_c),
        .drv_d     (out_d)
    );

endmodule

// File: rtl/fb_bridge_pwm_chk.sv
module fb_bridge_pwm_chk (
    input logic clk,
    input logic rst_n,
    input logic en,
    input logic out_a,
    input logic out_b,
    input logic out_c,
    input logic out_d
);

    // R4
    two_active_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({out_a, out_b, out_c, out_d}) <= 2);

    // R4
    legs_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_a && out_c) && !(out_b && out_d));

    // R2
    fwd_mod_leg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_d |-> (out_a && !out_c));

    // R3
    rev_mod_leg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_b |-> (out_c && !out_a));

    // R8
    swap_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_c) |-> (!out_b && !out_d));

    // R11
    disable_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> ({out_a, out_b, out_c, out_d} == 4'b0000));

endmodule

bind fb_bridge_pwm fb_bridge_pwm_chk u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (en),
    .out_a (out_a),
    .out_b (out_b),
    .out_c (out_c),
    .out_d (out_d)
);

// File: tb/fb_bridge_pwm_tb.sv
module fb_bridge_pwm_tb;

    localparam int CNT_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             en = 1'b0;
    logic             dir_rev = 1'b0;
    logic [1:0]       psc_sel = 2'b00;
    logic [CNT_W-1:0] period = '0;
    logic [CNT_W-1:0] duty = '0;
    logic             out_a, out_b, out_c, out_d;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // expectation context: cycle index since enable, effective period,
    // tick length, duty for period 0 and later, periods whose window swaps
    int gj, g_p, g_div, g_d0, g_d1, g_sw0, g_sw1;

    always #10 clk = ~clk;

    fb_bridge_pwm #(.CNT_W(CNT_W)) u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .dir_rev (dir_rev),
        .psc_sel (psc_sel),
        .period  (period),
        .duty    (duty),
        .out_a   (out_a),
        .out_b   (out_b),
        .out_c   (out_c),
        .out_d   (out_d)
    );

    function automatic logic [3:0] expect_abcd(int j);
        int  t, pi, c, dty, flips;
        bit  rev, inwin;
        t     = j / g_div;
        pi    = t / (g_p + 1);
        c     = t % (g_p + 1);
        dty   = (pi == 0) ? g_d0 : g_d1;
        flips = 0;
        if (g_sw0 >= 0 && pi > g_sw0) flips++;
        if (g_sw1 >= 0 && pi > g_sw1) flips++;
        rev   = (flips % 2) == 1;
        inwin = (c >= g_p - 3) && (pi == g_sw0 || pi == g_sw1);
        if (inwin)     return rev ? 4'b1000 : 4'b0010;
        else if (!rev) return {1'b1, 1'b0, 1'b0, (c < dty)};
        else           return {1'b0, (c < dty), 1'b1, 1'b0};
    endfunction

    task automatic check(string tag, logic [3:0] got, logic [3:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s cycle=%0d abcd got=%b expected=%b", tag, gj, got, exp);
        end
    endtask

    task automatic watch(int n, string tag);
        for (int i = 0; i < n; i++) begin
            check(tag, {out_a, out_b, out_c, out_d}, expect_abcd(gj));
            gj++;
            @(negedge clk);
        end
    endtask

    // leaves the bench at the falling edge of enabled cycle 0
    task automatic begin_run(int p, int d, logic [1:0] sel, int div, logic dir, string tag);
        @(negedge clk);
        en = 1'b0;
        @(negedge clk);
        period  = CNT_W'(p);
        duty    = CNT_W'(d);
        psc_sel = sel;
        dir_rev = dir;
        check(tag, {out_a, out_b, out_c, out_d}, 4'b0000);
        en = 1'b1;
        @(negedge clk);
        gj = 0; g_p = (p < 4) ? 4 : p; g_div = div;
        g_d0 = d; g_d1 = d; g_sw0 = -1; g_sw1 = -1;
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1", {out_a, out_b, out_c, out_d}, 4'b0000);
        rst_n = 1'b1;
        repeat (3) begin
            @(negedge clk);
            check("R1", {out_a, out_b, out_c, out_d}, 4'b0000);
        end
    endtask

    task automatic t_forward();
        begin_run(9, 4, 2'b00, 1, 1'b0, "R1");
        watch(30, "R2");
    endtask

    task automatic t_prescale();
        begin_run(5, 2, 2'b01, 4, 1'b0, "R5");
        watch(48, "R5");
        begin_run(5, 3, 2'b11, 16, 1'b0, "R5");
        watch(192, "R5");
        begin_run(5, 4, 2'b10, 16, 1'b0, "R5");
        watch(96, "R5");
    endtask

    task automatic t_short_period();
        begin_run(2, 3, 2'b00, 1, 1'b0, "R6");
        watch(15, "R6");
    endtask

    task automatic t_duty();
        begin_run(7, 2, 2'b00, 1, 1'b0, "R7");
        watch(3, "R7");
        duty = CNT_W'(6);
        g_d1 = 6;
        watch(21, "R7");
        begin_run(5, 0, 2'b00, 1, 1'b0, "R7");
        watch(12, "R7");
        begin_run(5, 200, 2'b00, 1, 1'b0, "R7");
        watch(12, "R7");
    endtask

    task automatic t_swap();
        begin_run(7, 5, 2'b00, 1, 1'b0, "R8");
        watch(2, "R8");
        dir_rev = 1'b1;
        g_sw0 = 0;
        watch(14, "R8");
        watch(16, "R3");
        dir_rev = 1'b0;
        g_sw1 = 4;
        watch(24, "R8");
    endtask

    task automatic t_withdraw();
        begin_run(9, 4, 2'b00, 1, 1'b0, "R9");
        watch(1, "R9");
        dir_rev = 1'b1;
        watch(1, "R9");
        dir_rev = 1'b0;
        watch(30, "R9");
    endtask

    task automatic t_late();
        begin_run(9, 4, 2'b00, 1, 1'b0, "R10");
        watch(7, "R10");
        dir_rev = 1'b1;
        g_sw0 = 1;
        watch(23, "R10");
    endtask

    task automatic t_disable();
        begin_run(9, 5, 2'b00, 1, 1'b0, "R11");
        watch(5, "R11");
        en = 1'b0;
        @(negedge clk);
        check("R11", {out_a, out_b, out_c, out_d}, 4'b0000);
        @(negedge clk);
        check("R11", {out_a, out_b, out_c, out_d}, 4'b0000);
        begin_run(9, 5, 2'b00, 1, 1'b1, "R11");
        g_sw0 = 0;
        watch(30, "R11");
    endtask

    initial begin
        t_reset();
        t_forward();
        t_prescale();
        t_short_period();
        t_duty();
        t_swap();
        t_withdraw();
        t_late();
        t_disable();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog expired got=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule